// File: doc/BRIEF.md
# Framed 16-bit Serial Slave Port

This block is the serial face of a data converter. An external master drives an active-low frame line, a serial clock and a data line. The block answers on a data output that it drives only while the frame is asserted. In every word it shifts one 16-bit word in and one 16-bit word out, both MSB first. The outgoing word always starts with a zero. Internal logic supplies the word to send and receives each completed incoming word together with a one-cycle strobe.

All three serial inputs are brought into the system clock domain through two-flop synchronisers, and the edges are found there. The system clock must run at least four times faster than the serial clock. Two framing styles are supported. In the first, the frame line is pulsed once per word. In the second, the frame line is held low and the words follow back to back, each one ended by its sixteenth rising clock edge. Raising and then lowering the frame line drops any partial word and realigns the port.

Top module: `frm_serial_port`

## Requirements
- R1: After reset, ser_dout_en is 0, ser_dout is 0, rx_valid is 0 and rx_word is 0.
- R2: ser_dout_en is 1 (drive) exactly while the synchronised frame_n is low. It rises two system clocks after frame_n falls and drops two system clocks after frame_n rises.
- R3: The first falling ser_clk edge of each word sets ser_dout to 0, whatever tx_word bit 15 holds.
- R4: Falling edges 2 to 16 of a word put tx_word bits 14 down to 0 on ser_dout, in that order.
- R5: ser_din is sampled on rising ser_clk edges, and the first sample becomes bit 15. After the 16th rising edge, rx_word holds the word and rx_valid is 1 for exactly one system clock.
- R6: tx_word is captured at the frame start and at each 16-bit boundary. A change of tx_word in the middle of a word has no effect on that word's output bits.
- R7: While frame_n stays low, each new run of 16 clocks forms a further word: a fresh leading zero, a freshly captured tx_word and its own rx_valid pulse.
- R8: frame_n going high in the middle of a word discards the partial word with no rx_valid pulse. The next frame starts again at bit 15.
- R9: ser_clk edges while frame_n is high change nothing. rx_valid stays 0, and ser_dout and ser_dout_en stay 0.
- R10: ser_dout changes only after a detected falling ser_clk edge or a frame edge, and it is 0 whenever ser_dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x ser_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select from the master |
| ser_clk | input | 1 | Serial clock, idle high |
| ser_din | input | 1 | Serial data in, sampled on the rising edge |
| tx_word | input | 16 | Word to transmit, from internal logic |
| ser_dout | output | 1 | Serial data out, changes after falling edges |
| ser_dout_en | output | 1 | Output drive enable, 1 = drive, 0 = high impedance |
| rx_word | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when rx_word updates |

## Verification
The hardest case to reach is the word boundary with the frame line held low. Here one rising edge must close the received word, reload the transmit word and restart the count, with no frame edge to help. The stimulus holds frame_n low across 32 serial clocks. It changes tx_word in the middle of the first word, so the change must stay out of that word and show up in the second. A frame cut off after seven bits, followed by a full frame, exercises realignment. A cycle-level reference model, fed the same pins with the synchroniser delay, is compared against every output on every clock.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  localparam logic [2:0] SYNC_IDLE = 3'b110; // {frame_n, ser_clk, ser_din} at rest
endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fsp_edge.sv
module fsp_edge
  import fsp_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  lvl,
  output edge_t ev
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= lvl;
  end

  assign ev.rise = lvl & ~prev;
  assign ev.fall = ~lvl & prev;
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clear,
  input  logic         shift,
  input  logic [W-1:0] word,
  output logic         bit_out
);
  logic [W-1:0] sr;

  // The top bit is forced to zero: every word leads with a zero.
  function automatic logic [W-1:0] lead_word(input logic [W-1:0] w);
    logic [W-1:0] r;
    r = w;
    r[W-1] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bit_out <= 1'b0;
    end else begin
      if (load)       sr <= lead_word(word);
      else if (shift) sr <= {sr[W-2:0], 1'b0};
      if (clear)      bit_out <= 1'b0;
      else if (shift) bit_out <= sr[W-1];
    end
  end
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          sample,
  input  logic          din,
  output logic [W-1:0]  word,
  output logic          valid,
  output logic [CW-1:0] bitcnt,
  output logic          word_end
);
  logic [W-1:0] acc;

  function automatic logic is_last(input logic [CW-1:0] c);
    return c == CW'(W - 1);
  endfunction

  assign word_end = sample & ~restart & is_last(bitcnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      bitcnt <= '0;
      word   <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= word_end;
      if (restart) begin
        acc    <= '0;
        bitcnt <= '0;
      end else if (sample) begin
        acc    <= {acc[W-2:0], din};
        bitcnt <= word_end ? '0 : bitcnt + 1'b1;
      end
      if (word_end) word <= {acc[W-2:0], din};
    end
  end
endmodule

// File: rtl/frm_serial_port.sv
module frm_serial_port
  import fsp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [WORD_W-1:0] tx_word,
  output logic              ser_dout,
  output logic              ser_dout_en,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic [2:0]    pins_s;
  logic          frame_s, sclk_s, din_s;
  edge_t         frm_ev, sclk_ev;
  logic          frame_act, frame_start, frame_end;
  logic          sck_rise, sck_fall, word_end, tx_bit;
  logic [CW-1:0] bitcnt;

  fsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({frame_n, ser_clk, ser_din}), .q(pins_s)
  );
  assign {frame_s, sclk_s, din_s} = pins_s;

  fsp_edge #(.RST_VAL(1'b1)) u_frm_edge (
    .clk(clk), .rst_n(rst_n), .lvl(frame_s), .ev(frm_ev)
  );
  fsp_edge #(.RST_VAL(1'b1)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .ev(sclk_ev)
  );

  assign frame_act   = ~frame_s;
  assign frame_start = frm_ev.fall;
  assign frame_end   = frm_ev.rise;
  assign sck_rise    = sclk_ev.rise & frame_act;
  assign sck_fall    = sclk_ev.fall & frame_act;

  fsp_rx #(.W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(frame_start | frame_end),
    .sample(sck_rise), .din(din_s), .word(rx_word), .valid(rx_valid),
    .bitcnt(bitcnt), .word_end(word_end)
  );

  fsp_tx #(.W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_start | word_end),
    .clear(frame_start | frame_end), .shift(sck_fall),
    .word(tx_word), .bit_out(tx_bit)
  );

  assign ser_dout_en = frame_act;
  assign ser_dout    = tx_bit & frame_act;
endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ser_dout,
  input logic          ser_dout_en,
  input logic          rx_valid,
  input logic          frame_start,
  input logic          frame_end,
  input logic          sck_rise,
  input logic          sck_fall,
  input logic [CW-1:0] bitcnt
);
  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dout_en) |-> frame_start);
  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_dout_en) |-> frame_end);
  // R3
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall && bitcnt == '0) |=> !ser_dout);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(sck_rise));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> bitcnt == '0);
  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_en |-> !ser_dout);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !frame_start && !frame_end && ser_dout_en)
      |=> (!ser_dout_en || $stable(ser_dout)));
endmodule

bind frm_serial_port fsp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
  .rx_valid(rx_valid), .frame_start(frame_start), .frame_end(frame_end),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .bitcnt(bitcnt)
);

// File: tb/sim_frm_serial_port.sv
module sim_frm_serial_port;
  localparam int HP = 4;
  localparam int LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_din = 1'b0;
  logic [15:0] tx_word = '0;
  logic        ser_dout, ser_dout_en, rx_valid;
  logic [15:0] rx_word;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  logic [15:0] words[$];

  always #2 clk = ~clk;

  frm_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .tx_word(tx_word), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: pin history stands in for the two-cycle synchroniser.
  bit f1, f2, f3, c1, c2, c3, d1, d2, d3;
  int m_cnt;
  logic [15:0] m_txl, m_acc, m_rxw;
  bit m_sdo, m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      {f1, f2, f3} = 3'b111; {c1, c2, c3} = 3'b111; {d1, d2, d3} = 3'b000;
      m_cnt = 0; m_txl = '0; m_acc = '0; m_rxw = '0; m_sdo = 0; m_valid = 0;
    end else begin
      m_valid = 0;
      if (!f2 && f3) begin
        m_cnt = 0; m_acc = '0; m_sdo = 0; m_txl = tx_word;
      end else if (f2 && !f3) begin
        m_cnt = 0; m_acc = '0; m_sdo = 0;
      end else if (!f2) begin
        if (!c2 && c3) m_sdo = (m_cnt == 0) ? 1'b0 : m_txl[15 - m_cnt];
        if (c2 && !c3) begin
          m_acc = {m_acc[14:0], d2};
          m_cnt++;
          if (m_cnt == 16) begin
            m_rxw = m_acc; m_valid = 1; m_cnt = 0; m_txl = tx_word;
          end
        end
      end
      f3 = f2; f2 = f1; f1 = frame_n;
      c3 = c2; c2 = c1; c1 = ser_clk;
      d3 = d2; d2 = d1; d1 = ser_din;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "model oe", ser_dout_en, !f2);
      chk("R10", "model dout", ser_dout, (!f2) ? m_sdo : 1'b0);
      chk("R5", "model valid", rx_valid, m_valid);
      chk("R5", "model word", rx_word, m_rxw);
      if (rx_valid) begin
        vcount++;
        words.push_back(rx_word);
      end
    end
  end

  task automatic clk_bits(input int n, input logic [31:0] din, input int chg_at,
                          input logic [15:0] chg_val, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) tx_word = chg_val;
      ser_clk = 1'b0;
      ser_din = din[n-1-i];
      repeat (HP) @(negedge clk);
      dout = {dout[30:0], ser_dout};
      ser_clk = 1'b1;
      repeat (HP) @(negedge clk);
    end
  endtask

  task automatic open_frame();
    frame_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic close_frame();
    frame_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] got;
    int v0;
    repeat (4) @(negedge clk);
    // R1
    chk("R1", "reset oe", ser_dout_en, 0);
    chk("R1", "reset dout", ser_dout, 0);
    chk("R1", "reset valid", rx_valid, 0);
    chk("R1", "reset word", rx_word, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R4 R5: pulsed frame, bit 15 of tx set but must go out as zero
    tx_word = 16'hA5C3; v0 = vcount;
    open_frame();
    chk("R2", "oe in frame", ser_dout_en, 1);
    clk_bits(16, 32'h3C96, -1, '0, got);
    close_frame();
    chk("R3", "lead zero", got[15], 0);
    chk("R4", "data bits", got[14:0], 15'h25C3);
    chk("R5", "one strobe", vcount - v0, 1);
    chk("R5", "rx word", words[$], 16'h3C96);
    chk("R2", "oe released", ser_dout_en, 0);

    // R4 R5: second pattern
    tx_word = 16'h7FFF; v0 = vcount;
    open_frame();
    clk_bits(16, 32'h8001, -1, '0, got);
    close_frame();
    chk("R4", "all ones", got[15:0], 16'h7FFF);
    chk("R5", "rx word 2", words[$], 16'h8001);

    // R6: tx change mid-word has no effect
    tx_word = 16'h1234;
    open_frame();
    clk_bits(16, 32'h0000, 4, 16'hFFFF, got);
    close_frame();
    chk("R6", "mid change ignored", got[15:0], 16'h1234);

    // R7: frame held low, two back-to-back words
    tx_word = 16'h0F0F; v0 = vcount;
    open_frame();
    clk_bits(32, 32'hBEEF1357, 8, 16'h4321, got);
    close_frame();
    chk("R7", "word1 out", got[31:16], 16'h0F0F);
    chk("R7", "word2 out", got[15:0], 16'h4321);
    chk("R7", "two strobes", vcount - v0, 2);
    chk("R7", "word1 in", words[$-1], 16'hBEEF);
    chk("R7", "word2 in", words[$], 16'h1357);

    // R8: partial word dropped, next frame realigned
    tx_word = 16'h00F0; v0 = vcount;
    open_frame();
    clk_bits(7, 32'h7F, -1, '0, got);
    close_frame();
    chk("R8", "no strobe partial", vcount - v0, 0);
    open_frame();
    clk_bits(16, 32'h0A0B, -1, '0, got);
    close_frame();
    chk("R8", "realigned out", got[15:0], 16'h00F0);
    chk("R8", "one strobe after", vcount - v0, 1);
    chk("R8", "realigned in", words[$], 16'h0A0B);

    // R9: clocks with frame high are ignored
    v0 = vcount;
    clk_bits(20, 32'hFFFFF, -1, '0, got);
    chk("R9", "dout idle", got, 0);
    chk("R9", "oe idle", ser_dout_en, 0);
    chk("R9", "no strobe idle", vcount - v0, 0);
    chk("R9", "word kept", rx_word, 16'h0A0B);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule